// File: doc/BRIEF.md
# Lane-Group Load Coalescer

This block takes one load request from a group of sixteen lanes and turns it into the smallest set of aligned memory reads that covers it. Each lane carries an enable bit and a byte address of one 4-byte word. Memory is only ever read in whole aligned blocks of 32, 64 or 128 bytes. The block therefore groups lanes that fall into the same block. It emits one read descriptor per group, carrying the block base, the block size and the mask of lanes that the read serves.

Every group starts from the lowest-numbered lane that is enabled and still waiting. It first takes the 128-byte aligned block around that lane's word. It then narrows the block to a 64-byte half, and again to a 32-byte quarter, whenever all waiting lanes that fall in the block also fit in that smaller piece. Those lanes are marked done, and the next group starts from the next waiting lane.

Descriptors leave through a ready/valid handshake at up to one per cycle. The final descriptor of a request carries a completion flag. A new request is accepted only after that final descriptor has been taken.

Top module: `coal_unit`

## Requirements
- R1: A request holds 16 lanes. Lane i takes its enable from `req_active[i]` and its byte address from `req_addr[32*i+31:32*i]`, with the two low address bits zero. `txn_size` encodes the block size: 0 means 32 bytes, 1 means 64 bytes, 2 means 128 bytes. `txn_base` is always a multiple of that size.
- R2: Each descriptor is anchored on the lowest-numbered lane that is enabled and not yet served. That lane is always in the descriptor's mask. The mask holds exactly those waiting lanes whose address lies in the 128-byte aligned block containing the anchor's address.
- R3: The size is 64 bytes when every masked lane lies in the same 64-byte half of that 128-byte block, and 32 bytes when they also share one 32-byte quarter. Otherwise it is 128 bytes. The base is the anchor address rounded down to the chosen size.
- R4: Descriptors repeat until no enabled lane is waiting. Their masks are non-empty and disjoint, and together they equal the enabled set.
- R5: A disabled lane never anchors a descriptor and never appears in any descriptor mask.
- R6: Sixteen lanes reading consecutive words of one 64-byte aligned block give a single 64-byte descriptor.
- R7: While `txn_valid` is high and `txn_ready` is low, the descriptor fields stay unchanged. With `txn_ready` held high, descriptors go out on consecutive cycles.
- R8: `req_ready` is low from the cycle after a request with at least one enabled lane is accepted until the cycle after its final descriptor is taken. The first descriptor is valid in the cycle after acceptance.
- R9: `txn_final` is high only with the last descriptor of a request. A request with no enabled lanes yields no descriptor and leaves `req_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_active | input | 16 | Per-lane enable |
| req_addr | input | 512 | Per-lane byte address, lane i at bits 32*i+31:32*i |
| txn_valid | output | 1 | Descriptor present |
| txn_ready | input | 1 | Memory takes the descriptor |
| txn_base | output | 32 | Aligned block base address |
| txn_size | output | 2 | Block size code (0:32 B, 1:64 B, 2:128 B) |
| txn_mask | output | 16 | Lanes served by this descriptor |
| txn_final | output | 1 | Last descriptor of the request |

## Verification
A request is accepted on the clock edge where `req_valid` and `req_ready` are both high. The first descriptor is due one edge later, and each later descriptor is due one edge after the previous one was taken. The bench drives and samples on the falling edge. It compares a descriptor only in a half-cycle where it has itself set `txn_ready` high, which is exactly when the descriptor is taken at the next rising edge. After each request, one more falling edge must show `txn_valid` low and `req_ready` high again. The expected descriptor list comes from a bench model. For each group, that model looks for the smallest block size whose lane set matches the 128-byte lane set. It runs over stride sweeps, base offsets, lane-enable patterns and three back-pressure modes.

// File: rtl/coal_pkg.sv
package coal_pkg;
   // size code 0 is the smallest block, each step up doubles it
   function automatic int unsigned size_bytes(input int unsigned min_bytes, input int unsigned code);
      return min_bytes << code;
   endfunction
endpackage

// File: rtl/coal_leader_pick.sv
module coal_leader_pick #(
   parameter int LANES = 16,
   localparam int LIDX = (LANES > 1) ? $clog2(LANES) : 1
) (
   input  logic [LANES-1:0] pending,
   output logic [LANES-1:0] leader_oh,
   output logic [LIDX-1:0]  leader_idx,
   output logic             any_pending
);
   logic [LANES:0] seen;
   assign seen[0] = 1'b0;

   for (genvar i = 0; i < LANES; i++) begin : g_chain
      assign seen[i+1]    = seen[i] | pending[i];
      assign leader_oh[i] = pending[i] & ~seen[i];
   end

   assign any_pending = seen[LANES];

   always_comb begin
      leader_idx = '0;
      for (int i = 0; i < LANES; i++)
         if (leader_oh[i]) leader_idx = LIDX'(i);
   end
endmodule

// File: rtl/coal_shrink.sv
module coal_shrink #(
   parameter int LANES  = 16,
   parameter int ADDR_W = 32,
   parameter int MIN_LG = 5,
   parameter int MAX_LG = 7,
   localparam int LEVELS = MAX_LG - MIN_LG,
   localparam int SZ_W   = (LEVELS > 0) ? $clog2(LEVELS + 1) : 1
) (
   input  logic [ADDR_W-1:0] lane_addr [LANES],
   input  logic [LANES-1:0]  served,
   input  logic [ADDR_W-1:0] leader_addr,
   output logic [SZ_W-1:0]   size_code,
   output logic [ADDR_W-1:0] base
);
   logic [LEVELS:0] keep;
   assign keep[0] = 1'b1;

   for (genvar k = 1; k <= LEVELS; k++) begin : g_lvl
      localparam int B = MAX_LG - k;
      logic [LANES-1:0] agree;
      for (genvar i = 0; i < LANES; i++) begin : g_lane
         assign agree[i] = ~served[i] | (lane_addr[i][B] == leader_addr[B]);
      end
      assign keep[k] = keep[k-1] & (&agree);
   end

   always_comb begin
      int sc;
      sc = LEVELS;
      for (int k = 1; k <= LEVELS; k++)
         if (keep[k]) sc = sc - 1;
      size_code = SZ_W'(sc);
   end

   always_comb begin
      base = leader_addr;
      for (int b = 0; b < MAX_LG; b++)
         if (b < MIN_LG + int'(size_code)) base[b] = 1'b0;
   end
endmodule

// File: rtl/coal_seg_match.sv
module coal_seg_match #(
   parameter int LANES  = 16,
   parameter int ADDR_W = 32,
   parameter int MIN_LG = 5,
   parameter int MAX_LG = 7,
   localparam int LEVELS = MAX_LG - MIN_LG,
   localparam int SZ_W   = (LEVELS > 0) ? $clog2(LEVELS + 1) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] lane_addr [LANES],
   input  logic [LANES-1:0]  pending,
   input  logic [LANES-1:0]  leader_oh,
   input  logic [ADDR_W-1:0] leader_addr,
   output logic [LANES-1:0]  served,
   output logic [SZ_W-1:0]   size_code,
   output logic [ADDR_W-1:0] base
);
   logic [LANES-1:0] same_seg;

   for (genvar i = 0; i < LANES; i++) begin : g_cmp
      assign same_seg[i] = lane_addr[i][ADDR_W-1:MAX_LG] == leader_addr[ADDR_W-1:MAX_LG];
   end

   assign served = pending & same_seg;

   coal_shrink #(
      .LANES(LANES), .ADDR_W(ADDR_W), .MIN_LG(MIN_LG), .MAX_LG(MAX_LG)
   ) u_shrink (
      .lane_addr  (lane_addr),
      .served     (served),
      .leader_addr(leader_addr),
      .size_code  (size_code),
      .base       (base)
   );

   // R2
   anchor_in_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|pending) |-> ((served & leader_oh) != '0));
endmodule

// File: rtl/coal_unit.sv
module coal_unit #(
   parameter int LANES         = 16,
   parameter int ADDR_W        = 32,
   parameter int WORD_BYTES    = 4,
   parameter int MIN_SEG_BYTES = 32,
   parameter int MAX_SEG_BYTES = 128,
   localparam int MIN_LG = $clog2(MIN_SEG_BYTES),
   localparam int MAX_LG = $clog2(MAX_SEG_BYTES),
   localparam int LEVELS = MAX_LG - MIN_LG,
   localparam int SZ_W   = (LEVELS > 0) ? $clog2(LEVELS + 1) : 1,
   localparam int LIDX   = (LANES > 1) ? $clog2(LANES) : 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     req_valid,
   output logic                     req_ready,
   input  logic [LANES-1:0]         req_active,
   input  logic [LANES*ADDR_W-1:0]  req_addr,
   output logic                     txn_valid,
   input  logic                     txn_ready,
   output logic [ADDR_W-1:0]        txn_base,
   output logic [SZ_W-1:0]          txn_size,
   output logic [LANES-1:0]         txn_mask,
   output logic                     txn_final
);
   import coal_pkg::*;

   if ((1 << MIN_LG) != MIN_SEG_BYTES || (1 << MAX_LG) != MAX_SEG_BYTES) begin : g_bad_pow
      $error("segment sizes must be powers of two");
   end
   if (MAX_LG < MIN_LG || MAX_LG >= ADDR_W) begin : g_bad_range
      $error("segment size range invalid for address width");
   end
   if (WORD_BYTES > MIN_SEG_BYTES || LANES < 1) begin : g_bad_word
      $error("word size or lane count invalid");
   end

   logic                busy_q;
   logic [LANES-1:0]    pend_q;
   logic [LANES-1:0]    act_q;
   logic [ADDR_W-1:0]   addr_q [LANES];

   logic [LANES-1:0]    leader_oh;
   logic [LIDX-1:0]     leader_idx;
   logic                any_pending;
   logic [LANES-1:0]    served;
   logic [LANES-1:0]    remain;
   logic                take_req;
   logic                take_txn;

   coal_leader_pick #(.LANES(LANES)) u_pick (
      .pending    (pend_q),
      .leader_oh  (leader_oh),
      .leader_idx (leader_idx),
      .any_pending(any_pending)
   );

   coal_seg_match #(
      .LANES(LANES), .ADDR_W(ADDR_W), .MIN_LG(MIN_LG), .MAX_LG(MAX_LG)
   ) u_match (
      .clk        (clk),
      .rst_n      (rst_n),
      .lane_addr  (addr_q),
      .pending    (pend_q),
      .leader_oh  (leader_oh),
      .leader_addr(addr_q[leader_idx]),
      .served     (served),
      .size_code  (txn_size),
      .base       (txn_base)
   );

   assign req_ready = ~busy_q;
   assign txn_valid = busy_q;
   assign txn_mask  = served;
   assign remain    = pend_q & ~served;
   assign txn_final = busy_q & (remain == '0);
   assign take_req  = req_valid & req_ready & (|req_active);
   assign take_txn  = txn_valid & txn_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         pend_q <= '0;
         act_q  <= '0;
      end else if (take_req) begin
         busy_q <= 1'b1;
         pend_q <= req_active;
         act_q  <= req_active;
      end else if (take_txn) begin
         pend_q <= remain;
         if (remain == '0) busy_q <= 1'b0;
      end
   end

   for (genvar i = 0; i < LANES; i++) begin : g_addr
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        addr_q[i] <= '0;
         else if (take_req) addr_q[i] <= req_addr[i*ADDR_W +: ADDR_W];
      end

      // R3
      lane_in_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (txn_valid && txn_mask[i]) |->
            ((addr_q[i] >> (MIN_LG + int'(txn_size))) == (txn_base >> (MIN_LG + int'(txn_size)))));
   end

   // R1
   base_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      txn_valid |-> ((txn_base & (ADDR_W'(size_bytes(MIN_SEG_BYTES, int'(txn_size)))
                                   - ADDR_W'(1))) == '0));
   // R2
   lowest_anchor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      txn_valid |-> ((txn_mask & (~txn_mask + 1'b1)) == (pend_q & (~pend_q + 1'b1))));
   // R4
   mask_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      txn_valid |-> (txn_mask != '0));
   // R5
   inactive_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      txn_valid |-> ((txn_mask & ~act_q) == '0));
   // R7
   hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (txn_valid && !txn_ready) |=> (txn_valid && $stable(txn_base) && $stable(txn_size)
                                     && $stable(txn_mask) && $stable(txn_final)));
   // R8
   no_accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      txn_valid |-> !req_ready);
   // R9
   final_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (txn_valid && txn_ready && txn_final) |=> (!txn_valid && req_ready));
   // R4
   pending_drains_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (txn_valid && txn_ready && !txn_final) |=> (txn_valid && any_pending));
endmodule

// File: tb/coal_unit_bench.sv
module coal_unit_bench;
   localparam int CLK_PERIOD = 10;
   localparam int L  = 16;
   localparam int AW = 32;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           req_valid = 1'b0;
   logic           req_ready;
   logic [L-1:0]   req_active = '0;
   logic [L*AW-1:0] req_addr = '0;
   logic           txn_valid;
   logic           txn_ready = 1'b0;
   logic [AW-1:0]  txn_base;
   logic [1:0]     txn_size;
   logic [L-1:0]   txn_mask;
   logic           txn_final;

   int errors = 0;
   int checks = 0;
   int cycles = 0;
   logic [15:0] lf = 16'hACE1;

   logic [L-1:0]  act_t;
   logic [AW-1:0] addr_t [L];
   logic [AW-1:0] eb [L];
   logic [1:0]    es [L];
   logic [L-1:0]  em [L];
   int            en;

   always #(CLK_PERIOD/2) clk = ~clk;

   coal_unit u_coal_unit (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_active(req_active), .req_addr(req_addr),
      .txn_valid(txn_valid), .txn_ready(txn_ready),
      .txn_base(txn_base), .txn_size(txn_size),
      .txn_mask(txn_mask), .txn_final(txn_final)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [15:0] lfsr_next(input logic [15:0] v);
      return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
   endfunction

   // model: smallest block whose lane set equals the 128-byte lane set
   task automatic model();
      logic [L-1:0] pend;
      pend = act_t;
      en = 0;
      while (pend != '0) begin
         int ld;
         logic [L-1:0] m128;
         ld = 0;
         for (int i = L-1; i >= 0; i--) if (pend[i]) ld = i;
         m128 = '0;
         for (int i = 0; i < L; i++)
            if (pend[i] && (addr_t[i] / 128) == (addr_t[ld] / 128)) m128[i] = 1'b1;
         for (int sz = 2; sz >= 0; sz--) begin
            logic [L-1:0] m;
            int by;
            by = 32 << sz;
            m = '0;
            for (int i = 0; i < L; i++)
               if (pend[i] && (addr_t[i] / by) == (addr_t[ld] / by)) m[i] = 1'b1;
            if (m == m128) begin
               es[en] = 2'(sz);
               eb[en] = (addr_t[ld] / by) * by;
            end
         end
         em[en] = m128;
         pend = pend & ~m128;
         en++;
      end
   endtask

   task automatic run_req(input int bp);
      int k;
      bit stalled;
      logic [AW-1:0] sb;
      logic [1:0] ss;
      logic [L-1:0] sm;
      logic [L-1:0] union_m;
      bit fin, idle;
      model();
      @(negedge clk);
      req_valid  = 1'b1;
      req_active = act_t;
      for (int i = 0; i < L; i++) req_addr[i*AW +: AW] = addr_t[i];
      chk(req_ready == 1'b1, "R8", "req_ready before accept", req_ready, 1);
      @(negedge clk);
      req_valid = 1'b0;
      k = 0; stalled = 0; fin = 0; idle = 0; union_m = '0;
      for (int cyc = 0; cyc < 200; cyc++) begin
         case (bp)
            0:       txn_ready = 1'b1;
            1:       txn_ready = cyc[0];
            default: begin lf = lfsr_next(lf); txn_ready = lf[0]; end
         endcase
         #1;
         if (stalled) begin
            chk(txn_valid && txn_base == sb && txn_size == ss && txn_mask == sm,
                "R7", "descriptor held under stall", {txn_base, txn_mask}, {sb, sm});
            stalled = 0;
         end
         if (txn_valid) begin
            chk(req_ready == 1'b0, "R8", "req_ready low while busy", req_ready, 0);
            if (txn_ready) begin
               if (k < en) begin
                  chk(txn_base == eb[k], "R2", "base", txn_base, eb[k]);
                  chk(txn_size == es[k], "R3", "size", txn_size, es[k]);
                  chk(txn_mask == em[k], "R2", "mask", txn_mask, em[k]);
               end else begin
                  chk(0, "R4", "extra descriptor", k, en);
               end
               chk((txn_mask & ~act_t) == '0, "R5", "inactive lane in mask", txn_mask, act_t);
               chk(txn_final == (k == en - 1), "R9", "final flag", txn_final, k == en - 1);
               union_m |= txn_mask;
               fin = txn_final;
               k++;
            end else begin
               stalled = 1; sb = txn_base; ss = txn_size; sm = txn_mask;
            end
         end else begin
            idle = 1;
         end
         @(negedge clk);
         if (fin || idle) break;
      end
      txn_ready = 1'b0;
      #1;
      chk(k == en, "R4", "descriptor count", k, en);
      chk(union_m == act_t, "R4", "union of masks", union_m, act_t);
      chk(!txn_valid && req_ready, "R9", "idle after request", {txn_valid, req_ready}, 2'b01);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=%0d expected<150000 cycles", cycles);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD*3);
      chk(txn_valid == 1'b0, "R8", "reset txn_valid", txn_valid, 0);
      chk(req_ready == 1'b1, "R8", "reset req_ready", req_ready, 1);
      rst_n = 1'b1;
      @(negedge clk);

      // R3 worked example: words 116..176
      act_t = '1;
      for (int i = 0; i < L; i++) addr_t[i] = AW'(116 + 4*i);
      run_req(0);
      chk(en == 2 && eb[0] == 96 && es[0] == 0 && em[0] == 16'h0007 && eb[1] == 128 && es[1] == 1,
          "R3", "example model list", en, 2);

      // R6 consecutive words in one 64-byte block
      for (int b = 0; b < 4; b++) begin
         act_t = '1;
         for (int i = 0; i < L; i++) addr_t[i] = AW'(b*64 + 4*i);
         run_req(b % 3);
         chk(en == 1 && es[0] == 1, "R6", "single 64-byte descriptor", en, 1);
      end

      // R1 R2 R3 stride sweep with offsets and back-pressure
      for (int s = 0; s <= 16; s++)
         for (int o = 0; o < 4; o++) begin
            int offs [4] = '{0, 4, 60, 124};
            act_t = '1;
            for (int i = 0; i < L; i++) addr_t[i] = AW'(4096 + offs[o] + 4*s*i);
            run_req((s + o) % 3);
         end

      // R5 lane-enable patterns, reversed order
      for (int p = 0; p < 6; p++) begin
         logic [L-1:0] pats [6] = '{16'hAAAA, 16'h5555, 16'h8001, 16'h00F0, 16'hF00F, 16'h0001};
         act_t = pats[p];
         for (int i = 0; i < L; i++) addr_t[i] = AW'(1024 - 8*i);
         run_req(p % 3);
      end

      // R9 no enabled lanes
      act_t = '0;
      for (int i = 0; i < L; i++) addr_t[i] = AW'(4*i);
      run_req(0);
      chk(en == 0, "R9", "empty request model", en, 0);

      // R2 broadcast to one word
      act_t = '1;
      for (int i = 0; i < L; i++) addr_t[i] = AW'(200);
      run_req(1);

      // R4 R7 pseudo-random patterns
      for (int r = 0; r < 60; r++) begin
         lf = lfsr_next(lf);
         act_t = lf;
         for (int i = 0; i < L; i++) begin
            lf = lfsr_next(lf);
            addr_t[i] = AW'({lf[9:0], 2'b00});
         end
         run_req(r % 3);
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule